// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Event Transfer Channels

This block gathers interrupt requests from up to 32 sources. Each source has a pending flag and a small setting: an enable, a 4-bit level and a 2-bit group. Every cycle the block finds the best pending, enabled request, ranked by level first and group second. It serves that request only if its level is strictly above the priority the CPU is running at. A served request either goes to the CPU as an interrupt, with a vector number equal to the source index and the new priority level, or becomes a single data move that needs no CPU work.

Requests at the two top levels, 14 and 15, are tied to eight transfer channels by their level and group. Each channel holds a transfer count, a 16-bit source address, a 16-bit destination address, a byte/word select and two auto-increment bits. While the count is non-zero, one request moves one item: one read cycle, then one write cycle on a simple memory port. After that move the count drops by one. Once the count reaches zero, the next request on that channel is passed to the CPU as an ordinary interrupt. Saving the CPU context on entry is left to the CPU.

Top module: `irq_pec_ctrl`

## Requirements
- R1: After reset, no interrupt is offered (`irq_valid`=0) and the memory port is idle (`mem_rd`=0, `mem_wr`=0).
- R2: A one-cycle pulse on `req_set[i]` sets pending flag i, and the flag stays set until the request is serviced. A pending source whose enable is 0 is never offered, and it is offered as soon as it is enabled.
- R3: A candidate is offered only if its level is strictly greater than `cpu_prio`. A source with level 0 is never offered.
- R4: Among pending, enabled sources with a non-zero level, the one with the higher level wins. At equal level the higher group wins. If both level and group are equal, the lower source index wins.
- R5: While `irq_valid` is 1, `irq_vector` equals the winning source index and `irq_level` equals its level.
- R6: When `irq_ack` is 1 in a cycle where `irq_valid` is 1, the winner's pending flag is cleared at that clock edge, and the next best request is offered in the following cycle.
- R7: A winner at level 14 or 15 whose channel count is non-zero is served as a transfer and does not raise `irq_valid`. Its channel number is 4·(level−14)+group, so level 14 maps to channels 0–3 and level 15 to channels 4–7.
- R8: A transfer begins in the cycle after the request is seen. It takes one cycle with `mem_rd`=1 and `mem_addr` equal to the source address. The next cycle has `mem_wr`=1, `mem_addr` equal to the destination address and `mem_wdata` equal to the data read. In byte mode (`word`=0), `mem_byte`=1 and `mem_wdata`[15:8]=0.
- R9: At the end of a transfer the count drops by one. Each pointer whose increment bit is set advances by 2 in word mode or by 1 in byte mode.
- R10: A request at level 14 or 15 whose channel count is zero is offered to the CPU as an interrupt.
- R11: While a transfer is in progress, `irq_valid` stays 0 even when other requests are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NSRC | Per-source request pulse |
| cfg_we | input | 1 | Write source setting |
| cfg_idx | input | IW | Source index for cfg write |
| cfg_en | input | 1 | Source enable |
| cfg_lvl | input | 4 | Source level |
| cfg_grp | input | 2 | Source group |
| ch_we | input | 1 | Write channel setting |
| ch_idx | input | 3 | Channel index |
| ch_cnt | input | 8 | Transfer count |
| ch_src | input | 16 | Source address |
| ch_dst | input | 16 | Destination address |
| ch_word | input | 1 | 1 = word, 0 = byte |
| ch_src_inc | input | 1 | Auto-increment source address |
| ch_dst_inc | input | 1 | Auto-increment destination address |
| cpu_prio | input | 4 | Current CPU priority |
| irq_ack | input | 1 | CPU takes the offered interrupt |
| irq_valid | output | 1 | Interrupt offered |
| irq_vector | output | IW | Winning source index |
| irq_level | output | 4 | New CPU priority |
| mem_rd | output | 1 | Transfer read cycle |
| mem_wr | output | 1 | Transfer write cycle |
| mem_byte | output | 1 | Byte-sized access |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the read cycle |

## Verification
The winner selection is run over a deterministic series of patterns: all sixteen sources are set up with mixed levels, groups and enables, and then drained one acknowledge at a time. This separates ranking by level from ranking by group, exposes index tie-breaking, and shows that disabled flags survive. A full sweep of level against CPU priority shows whether the comparison is strict. Word and byte transfers with different increment settings check the address order, the data narrowing and pointer advance. A transfer that runs alongside a lower pending interrupt shows the stall, and a drained channel shows the fallback to an interrupt.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int LVL_W  = 4;
    localparam int GRP_W  = 2;
    localparam int RANK_W = LVL_W + GRP_W;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int NCHAN  = 8;
    localparam int CH_W   = $clog2(NCHAN);
    localparam logic [LVL_W-1:0] XFER_LVL = 4'd14;

    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] lvl;
        logic [GRP_W-1:0] grp;
    } src_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              word;
        logic              sinc;
        logic              dinc;
    } chan_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_e;

    // level 14 -> channels 0..3, level 15 -> channels 4..7
    function automatic logic [CH_W-1:0] chan_of(logic [LVL_W-1:0] lvl, logic [GRP_W-1:0] grp);
        return {lvl[0], grp};
    endfunction

    function automatic logic [ADDR_W-1:0] step_ptr(logic [ADDR_W-1:0] p, logic word, logic inc);
        return inc ? (p + (word ? ADDR_W'(2) : ADDR_W'(1))) : p;
    endfunction
endpackage

// File: rtl/ipc_src_regs.sv
module ipc_src_regs
    import ipc_pkg::*;
#(
    parameter int NSRC = 16,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [IW-1:0]         cfg_idx,
    input  src_cfg_t              cfg_data,
    input  logic [NSRC-1:0]       req_set,
    input  logic                  clr_en,
    input  logic [IW-1:0]         clr_idx,
    output src_cfg_t [NSRC-1:0]   cfg_q,
    output logic [NSRC-1:0]       pend_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i]  <= '0;
                pend_q[i] <= 1'b0;
            end else begin
                if (cfg_we && cfg_idx == IW'(i))
                    cfg_q[i] <= cfg_data;
                pend_q[i] <= req_set[i] | (pend_q[i] & ~(clr_en && clr_idx == IW'(i)));
            end
        end
    end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
#(
    parameter int NSRC = 16,
    localparam int IW  = $clog2(NSRC)
) (
    input  src_cfg_t [NSRC-1:0] cfg,
    input  logic [NSRC-1:0]     pend,
    output logic                found,
    output logic [IW-1:0]       win_idx,
    output logic [LVL_W-1:0]    win_lvl,
    output logic [GRP_W-1:0]    win_grp
);
    logic [RANK_W-1:0] best;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        win_grp = '0;
        best    = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && cfg[i].en && cfg[i].lvl != '0) begin
                // strict compare keeps the lower index on a tie
                if (!found || {cfg[i].lvl, cfg[i].grp} > best) begin
                    found   = 1'b1;
                    win_idx = IW'(i);
                    win_lvl = cfg[i].lvl;
                    win_grp = cfg[i].grp;
                    best    = {cfg[i].lvl, cfg[i].grp};
                end
            end
        end
    end
endmodule

// File: rtl/ipc_chan_bank.sv
module ipc_chan_bank
    import ipc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ch_we,
    input  logic [CH_W-1:0] ch_idx,
    input  chan_t           ch_data,
    input  logic [CH_W-1:0] sel,
    input  logic            upd,
    output chan_t           cur
);
    chan_t chans [NCHAN];

    assign cur = chans[sel];

    for (genvar c = 0; c < NCHAN; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                chans[c] <= '0;
            end else if (ch_we && ch_idx == CH_W'(c)) begin
                chans[c] <= ch_data;
            end else if (upd && sel == CH_W'(c)) begin
                chans[c].cnt <= chans[c].cnt - CNT_W'(1);
                chans[c].src <= step_ptr(chans[c].src, chans[c].word, chans[c].sinc);
                chans[c].dst <= step_ptr(chans[c].dst, chans[c].word, chans[c].dinc);
            end
        end
    end
endmodule

// File: rtl/irq_pec_ctrl.sv
module irq_pec_ctrl
    import ipc_pkg::*;
#(
    parameter int NSRC = 16,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   req_set,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_idx,
    input  logic              cfg_en,
    input  logic [3:0]        cfg_lvl,
    input  logic [1:0]        cfg_grp,
    input  logic              ch_we,
    input  logic [2:0]        ch_idx,
    input  logic [7:0]        ch_cnt,
    input  logic [15:0]       ch_src,
    input  logic [15:0]       ch_dst,
    input  logic              ch_word,
    input  logic              ch_src_inc,
    input  logic              ch_dst_inc,
    input  logic [3:0]        cpu_prio,
    input  logic              irq_ack,
    output logic              irq_valid,
    output logic [IW-1:0]     irq_vector,
    output logic [3:0]        irq_level,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_byte,
    output logic [15:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);
    src_cfg_t [NSRC-1:0] cfg_q;
    logic [NSRC-1:0]     pend_q;
    logic                found;
    logic [IW-1:0]       win_idx;
    logic [LVL_W-1:0]    win_lvl;
    logic [GRP_W-1:0]    win_grp;
    xfer_st_e            st_q;
    logic [CH_W-1:0]     act_ch_q;
    logic [CH_W-1:0]     sel_ch;
    logic [DATA_W-1:0]   data_q;
    chan_t               cur;
    logic                accept, win_xfer, clr_en;

    ipc_src_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data('{en: cfg_en, lvl: cfg_lvl, grp: cfg_grp}),
        .req_set(req_set), .clr_en(clr_en), .clr_idx(win_idx),
        .cfg_q(cfg_q), .pend_q(pend_q)
    );

    ipc_arbiter #(.NSRC(NSRC)) u_arb (
        .cfg(cfg_q), .pend(pend_q), .found(found),
        .win_idx(win_idx), .win_lvl(win_lvl), .win_grp(win_grp)
    );

    assign sel_ch = (st_q == ST_IDLE) ? chan_of(win_lvl, win_grp) : act_ch_q;

    ipc_chan_bank u_bank (
        .clk(clk), .rst(rst), .ch_we(ch_we), .ch_idx(ch_idx),
        .ch_data('{cnt: ch_cnt, src: ch_src, dst: ch_dst, word: ch_word,
                   sinc: ch_src_inc, dinc: ch_dst_inc}),
        .sel(sel_ch), .upd(st_q == ST_WR), .cur(cur)
    );

    assign accept    = (st_q == ST_IDLE) && found && (win_lvl > cpu_prio);
    assign win_xfer  = accept && (win_lvl >= XFER_LVL) && (cur.cnt != '0);
    assign irq_valid = accept && !win_xfer;
    assign clr_en    = win_xfer || (irq_valid && irq_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            act_ch_q <= '0;
            data_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (win_xfer) begin
                    st_q     <= ST_RD;
                    act_ch_q <= sel_ch;
                end
                ST_RD: begin
                    data_q <= cur.word ? mem_rdata : {8'h00, mem_rdata[7:0]};
                    st_q   <= ST_WR;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign irq_vector = win_idx;
    assign irq_level  = win_lvl;
    assign mem_rd     = (st_q == ST_RD);
    assign mem_wr     = (st_q == ST_WR);
    assign mem_byte   = (st_q != ST_IDLE) && !cur.word;
    assign mem_addr   = (st_q == ST_RD) ? cur.src : cur.dst;
    assign mem_wdata  = data_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  cpu_prio,
    input logic        irq_valid,
    input logic [3:0]  irq_level,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        mem_byte,
    input logic [15:0] mem_wdata
);
    assert_rdwr_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_rd_then_wr_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr);

    assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd));

    assert_byte_narrow_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_byte) |-> (mem_wdata[15:8] == 8'h00));

    assert_above_cpu_R3: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level > cpu_prio));

    assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> !irq_valid);
endmodule

bind irq_pec_ctrl ipc_checker u_chk (
    .clk(clk), .rst(rst), .cpu_prio(cpu_prio), .irq_valid(irq_valid),
    .irq_level(irq_level), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_byte(mem_byte), .mem_wdata(mem_wdata)
);

// File: tb/tb_irq_pec_ctrl.sv
module tb_irq_pec_ctrl;
    localparam int NSRC = 16;
    localparam int IW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSRC-1:0] req_set = '0;
    logic cfg_we = 0, cfg_en = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [3:0] cfg_lvl = '0;
    logic [1:0] cfg_grp = '0;
    logic ch_we = 0, ch_word = 0, ch_src_inc = 0, ch_dst_inc = 0;
    logic [2:0] ch_idx = '0;
    logic [7:0] ch_cnt = '0;
    logic [15:0] ch_src = '0, ch_dst = '0;
    logic [3:0] cpu_prio = '0;
    logic irq_ack = 0;
    logic irq_valid, mem_rd, mem_wr, mem_byte;
    logic [IW-1:0] irq_vector;
    logic [3:0] irq_level;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    function automatic logic [15:0] rd_of(logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction
    assign mem_rdata = rd_of(mem_addr);

    irq_pec_ctrl #(.NSRC(NSRC)) dut (
        .clk(clk), .rst(rst), .req_set(req_set), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .cfg_grp(cfg_grp), .ch_we(ch_we),
        .ch_idx(ch_idx), .ch_cnt(ch_cnt), .ch_src(ch_src), .ch_dst(ch_dst),
        .ch_word(ch_word), .ch_src_inc(ch_src_inc), .ch_dst_inc(ch_dst_inc),
        .cpu_prio(cpu_prio), .irq_ack(irq_ack), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_level(irq_level), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_byte(mem_byte), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0;
    bit m_en [NSRC];
    int m_lvl [NSRC];
    int m_grp [NSRC];
    bit m_pend [NSRC];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_src(input int i, input bit en, input int lvl, input int grp);
        cfg_we = 1; cfg_idx = IW'(i); cfg_en = en; cfg_lvl = 4'(lvl); cfg_grp = 2'(grp);
        m_en[i] = en; m_lvl[i] = lvl; m_grp[i] = grp;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_ch(input int c, input int cnt, input int s, input int d,
                          input bit w, input bit si, input bit di);
        ch_we = 1; ch_idx = 3'(c); ch_cnt = 8'(cnt); ch_src = 16'(s); ch_dst = 16'(d);
        ch_word = w; ch_src_inc = si; ch_dst_inc = di;
        @(negedge clk);
        ch_we = 0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        req_set = m;
        for (int i = 0; i < NSRC; i++) if (m[i]) m_pend[i] = 1;
        @(negedge clk);
        req_set = '0;
    endtask

    task automatic ack();
        irq_ack = 1;
        @(negedge clk);
        irq_ack = 0;
    endtask

    function automatic int model_win(input int p);
        int best = -1;
        for (int i = 0; i < NSRC; i++)
            if (m_pend[i] && m_en[i] && m_lvl[i] != 0)
                if (best < 0 || m_lvl[i]*4 + m_grp[i] > m_lvl[best]*4 + m_grp[best])
                    best = i;
        if (best >= 0 && m_lvl[best] <= p) best = -1;
        return best;
    endfunction

    // compare offered interrupt with the model; returns expected winner
    task automatic step_check(input string req, output int w);
        w = model_win(int'(cpu_prio));
        chk(irq_valid == (w >= 0), req, irq_valid, w >= 0);
        if (w >= 0) begin
            chk(irq_vector == IW'(w), "R5 vector", irq_vector, w);
            chk(irq_level == 4'(m_lvl[w]), "R5 level", irq_level, m_lvl[w]);
        end
    endtask

    task automatic drain(input string req);
        int w;
        for (int k = 0; k <= NSRC; k++) begin
            step_check(req, w);
            if (w < 0) break;
            ack();
            m_pend[w] = 0;
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w;
        for (int i = 0; i < NSRC; i++) begin m_en[i] = 0; m_lvl[i] = 0; m_grp[i] = 0; m_pend[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(irq_valid == 0, "R1 irq_valid", irq_valid, 0);
        chk(mem_rd == 0 && mem_wr == 0, "R1 mem idle", {mem_rd, mem_wr}, 0);

        // R3 level vs cpu priority sweep (level 0 never offered)
        for (int l = 0; l < 14; l++) begin
            for (int p = 0; p < 16; p++) begin
                set_src(3, 1, l, 1);
                cpu_prio = 4'(p);
                pulse(16'h0008);
                step_check("R3 level above cpu_prio", w);
                cpu_prio = 0;
                w = model_win(0);
                if (w >= 0) begin ack(); m_pend[w] = 0; end
            end
        end
        set_src(3, 0, 0, 0);

        // R4 R5 R6 R2 sweep of mixed configurations, drained one ack at a time
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < NSRC; i++)
                set_src(i, ((i + t) % 5) != 0, (t*7 + i*5) % 14, (i*3 + t) % 4);
            pulse(16'((t * 16'h3A5B) ^ (t << 3) ^ 16'h1248));
            drain("R4 ranking / R6 ack clears");
        end
        // explicit equal-setting tie: lower index wins (R4)
        set_src(9, 1, 7, 2);
        set_src(12, 1, 7, 2);
        pulse(16'h1200);
        chk(irq_vector == 4'd9 && irq_valid, "R4 tie lower index", irq_vector, 9);
        ack(); m_pend[9] = 0;
        chk(irq_vector == 4'd12 && irq_valid, "R6 next offered", irq_vector, 12);
        ack(); m_pend[12] = 0;

        // clear leftovers, then disable everyone
        for (int i = 0; i < NSRC; i++) set_src(i, 1, 1, 0);
        drain("R6 drain");
        for (int i = 0; i < NSRC; i++) set_src(i, 0, 0, 0);

        // R2 disabled pending is kept and offered once enabled
        set_src(1, 0, 5, 0);
        pulse(16'h0002);
        @(negedge clk);
        chk(irq_valid == 0, "R2 disabled not offered", irq_valid, 0);
        set_src(1, 1, 5, 0);
        chk(irq_valid == 1 && irq_vector == 4'd1, "R2 enabled offered", irq_vector, 1);
        ack(); m_pend[1] = 0;
        chk(irq_valid == 0, "R6 flag cleared", irq_valid, 0);

        // R7 R8 R9 R11 word transfer on channel 6 (level 15 group 2)
        set_ch(6, 2, 16'h1000, 16'h2001, 1, 1, 0);
        set_src(4, 1, 15, 2);
        set_src(10, 1, 13, 0);
        pulse(16'h0410);
        chk(irq_valid == 0, "R7 no interrupt for transfer", irq_valid, 0);
        @(negedge clk);
        chk(mem_rd == 1 && mem_wr == 0, "R8 read cycle", {mem_rd, mem_wr}, 2);
        chk(mem_addr == 16'h1000, "R7 channel source address", mem_addr, 16'h1000);
        chk(irq_valid == 0, "R11 stall in read", irq_valid, 0);
        @(negedge clk);
        chk(mem_wr == 1 && mem_rd == 0, "R8 write cycle", {mem_rd, mem_wr}, 1);
        chk(mem_addr == 16'h2001, "R8 dest address", mem_addr, 16'h2001);
        chk(mem_wdata == rd_of(16'h1000), "R8 word data", mem_wdata, rd_of(16'h1000));
        chk(mem_byte == 0, "R8 word size", mem_byte, 0);
        chk(irq_valid == 0, "R11 stall in write", irq_valid, 0);
        @(negedge clk);
        chk(irq_valid == 1 && irq_vector == 4'd10, "R11 pending offered after", irq_vector, 10);
        ack();
        pulse(16'h0010);
        @(negedge clk);
        chk(mem_rd == 1 && mem_addr == 16'h1002, "R9 word src +2", mem_addr, 16'h1002);
        @(negedge clk);
        chk(mem_wr == 1 && mem_addr == 16'h2001, "R9 dst held", mem_addr, 16'h2001);
        @(negedge clk);
        pulse(16'h0010);
        chk(irq_valid == 1 && irq_vector == 4'd4 && irq_level == 4'd15,
            "R10 count zero gives interrupt", {irq_valid, irq_vector}, 16'h14);
        chk(mem_rd == 0, "R10 no read", mem_rd, 0);
        ack();

        // R8 R9 byte transfer on channel 1 (level 14 group 1)
        set_ch(1, 2, 16'h3005, 16'h4000, 0, 0, 1);
        set_src(7, 1, 14, 1);
        for (int k = 0; k < 2; k++) begin
            pulse(16'h0080);
            @(negedge clk);
            chk(mem_rd == 1 && mem_addr == 16'h3005, "R9 byte src held", mem_addr, 16'h3005);
            chk(mem_byte == 1, "R8 byte size", mem_byte, 1);
            @(negedge clk);
            chk(mem_wr == 1 && mem_addr == 16'(16'h4000 + k), "R9 byte dst +1", mem_addr, 16'h4000 + k);
            chk(mem_wdata == {8'h00, rd_of(16'h3005) & 16'h00FF}[15:0], "R8 byte data",
                mem_wdata, rd_of(16'h3005) & 16'h00FF);
            @(negedge clk);
        end
        // R3 transfer level must also beat cpu priority
        set_ch(1, 1, 16'h3005, 16'h4000, 0, 0, 1);
        cpu_prio = 4'd15;
        pulse(16'h0080);
        @(negedge clk);
        chk(mem_rd == 0 && irq_valid == 0, "R3 transfer blocked by cpu_prio", {mem_rd, irq_valid}, 0);
        cpu_prio = 4'd0;
        @(negedge clk);
        chk(mem_rd == 1, "R7 transfer after prio drop", mem_rd, 1);
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule